// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block is the receive half of a bus-mastering Ethernet controller. Once enabled, it walks a ring of descriptors in shared memory. Each descriptor is four 32-bit words: status, control, buffer address and next-descriptor address. The block only uses a descriptor when the host owns it over to the engine. It packs the incoming byte stream into 32-bit words and writes them to that descriptor's buffer. After the last byte of the frame it writes a completion status word, which returns the descriptor to the host.

If the engine reaches a descriptor still held by the host, it stops writing to memory. It drains every arriving frame and counts each one as missed. Between frames it reads the status word again, until the host hands the descriptor back. Descriptors sit 16 bytes apart. A flag in the control word sends the engine back to the ring base. Each frame fits in one buffer: bytes beyond the buffer size are dropped and the frame is flagged as bad.

Both the frame input and the memory port use valid/ready handshakes. A byte moves when `in_valid` and `in_ready` are both high at a clock edge. A memory access completes when `mem_req` and `mem_ready` are both high at a clock edge. Once raised, `mem_req` and its address, write data and write flag stay unchanged until `mem_ready` is seen. Read data must be valid in the cycle that `mem_ready` is high. The frame source may hold a byte for as long as it likes; the engine drops `in_ready` while it is busy on the memory port.

Top module: `ringrx_dma`

## Requirements
- R1: During reset and right after it, `mem_req` and `in_ready` are low and `missed_cnt` is zero.
- R2: On enable, the engine captures `ring_base` (low two bits forced to zero) as the first descriptor address. It reads the status word of a descriptor at offset 0. If bit 31 of that word is 1, it then reads the control word at offset 4 and the buffer address at offset 8.
- R3: Frame bytes are written little-endian into consecutive words starting at the buffer address (low two bits forced to zero). Byte k of the frame goes to bits 8*(k mod 4)+7 : 8*(k mod 4). In a final partial word, the lanes with no byte are zero.
- R4: After the last data word, the engine writes the status word at the descriptor address. In that word, bit 31 is 0, bits 30:16 hold the number of bytes stored, bit 8 is 1, bit 15 is the error summary, and every other bit is 0.
- R5: If `in_err` is high on any accepted byte of a frame, bit 15 of that frame's status word is set.
- R6: The buffer size is taken from control-word bits 10:0. Bytes beyond that size are accepted but not written. The stored length then equals the size, and bit 15 is set.
- R7: After completing a descriptor, the next descriptor is 16 bytes further on. If bit 25 of the descriptor's control word is 1, the next descriptor is the captured ring base instead.
- R8: A status word with bit 31 at 0 stalls the engine. Arriving frames are then accepted and discarded, with no memory write. `missed_cnt` rises by one per discarded frame and saturates at its maximum. Between frames the status word is read again.
- R9: When `rx_enable` is low, the engine goes idle at the next descriptor or frame boundary, with `in_ready` and `mem_req` low. A later enable restarts the ring from `ring_base`.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R11: `in_ready` is never high in a cycle where `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive run control |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Byte carries a receive error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| missed_cnt | output | MISS_W | Saturating count of discarded frames |

## Verification
A memory write is due at the edge where `mem_ready` meets an open request. The bench therefore samples the port at the falling edge before that edge, compares the write with the head of a queue the model filled when the frame was sent, and applies it to the bench memory. The model steps `missed_cnt` on the edge that takes the last byte of a dropped frame. The bench compares the model count with the port at every falling edge, so that check passes only if the count moves on that same edge. The bench stretches accesses by holding `mem_ready` low one cycle in three. Before each frame it waits long enough for the descriptor fetch to end, so every expected value depends only on the order of events, not on memory latency.

// File: rtl/ringrx_pkg.sv
package ringrx_pkg;
  localparam int WORD_BYTES   = 4;
  localparam int DESC_STRIDE  = 16;
  localparam int CTRL_OFS     = 4;
  localparam int BUFP_OFS     = 8;
  localparam int OWN_BIT      = 31;
  localparam int WRAP_BIT     = 25;
  localparam int ERR_BIT      = 15;
  localparam int LAST_BIT     = 8;
  localparam int LEN_LSB      = 16;
  localparam int LEN_MSB      = 30;
  localparam int LEN_FIELD_W  = LEN_MSB - LEN_LSB + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_STAT,
    S_RD_CTRL,
    S_RD_BUF,
    S_RECV,
    S_WR_DATA,
    S_WR_STAT,
    S_STALL
  } rx_state_e;
endpackage

// File: rtl/ringrx_packer.sv
module ringrx_packer
  import ringrx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic             err_in,
  input  logic [LEN_W-1:0] limit,
  input  logic             word_sent,
  output logic [31:0]      word,
  output logic [2:0]       nbytes,
  output logic [LEN_W-1:0] stored,
  output logic             trunc,
  output logic             err_seen,
  output logic             room
);
  localparam int LANE_SEL_W = $clog2(WORD_BYTES);

  assign room = (stored != limit);

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (frame_clr || word_sent)
        lane_q <= '0;
      else if (take && room && (nbytes[LANE_SEL_W-1:0] == LANE_SEL_W'(g)))
        lane_q <= byte_in;
    end
    assign word[8*g +: 8] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes   <= '0;
      stored   <= '0;
      trunc    <= 1'b0;
      err_seen <= 1'b0;
    end else if (frame_clr) begin
      nbytes   <= '0;
      stored   <= '0;
      trunc    <= 1'b0;
      err_seen <= 1'b0;
    end else begin
      if (word_sent) nbytes <= '0;
      if (take) begin
        if (err_in) err_seen <= 1'b1;
        if (room) begin
          nbytes <= nbytes + 3'd1;
          stored <= stored + 1'b1;
        end else begin
          trunc <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ringrx_sat_counter.sv
module ringrx_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (bump && (count != TOP))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/ringrx_next_desc.sv
module ringrx_next_desc #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic              wrap,
  output logic [ADDR_W-1:0] next
);
  assign next = wrap ? base : (cur + ADDR_W'(STRIDE));
endmodule

// File: rtl/ringrx_dma.sv
module ringrx_dma
  import ringrx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_cnt
);
  rx_state_e         state;
  logic [ADDR_W-1:0] cur_q, base_q, buf_q, next_desc;
  logic              wrap_q, eof_q, mid_q;
  logic [LEN_W-1:0]  limit_q;

  logic              accept, take, frame_clr, word_sent, miss_pulse, xfer;
  logic [31:0]       pack_word, stat_word;
  logic [2:0]        nbytes, nb_next;
  logic [LEN_W-1:0]  stored;
  logic              trunc, err_seen, room;
  logic              rdata_unused;

  assign rdata_unused = ^{mem_rdata, ring_base[1:0]};

  assign xfer       = mem_req && mem_ready;
  assign accept     = in_valid && in_ready;
  assign take       = accept && (state == S_RECV);
  assign miss_pulse = accept && (state == S_STALL) && in_last;
  assign frame_clr  = (state == S_RD_BUF) && mem_ready;
  assign word_sent  = (state == S_WR_DATA) && mem_ready;
  assign nb_next    = nbytes + {2'b00, room};

  assign in_ready = ((state == S_RECV) || (state == S_STALL)) && (rx_enable || mid_q);
  assign mem_req  = (state == S_RD_STAT) || (state == S_RD_CTRL) || (state == S_RD_BUF) ||
                    (state == S_WR_DATA) || (state == S_WR_STAT);
  assign mem_we   = (state == S_WR_DATA) || (state == S_WR_STAT);

  always_comb begin
    stat_word                  = '0;
    stat_word[LEN_MSB:LEN_LSB] = LEN_FIELD_W'(stored);
    stat_word[ERR_BIT]         = err_seen || trunc;
    stat_word[LAST_BIT]        = 1'b1;
  end

  always_comb begin
    mem_addr  = cur_q;
    mem_wdata = '0;
    case (state)
      S_RD_CTRL: mem_addr = cur_q + ADDR_W'(CTRL_OFS);
      S_RD_BUF:  mem_addr = cur_q + ADDR_W'(BUFP_OFS);
      S_WR_DATA: begin
        mem_addr  = buf_q;
        mem_wdata = pack_word;
      end
      S_WR_STAT: mem_wdata = stat_word;
      default:   mem_addr = cur_q;
    endcase
  end

  ringrx_packer #(.LEN_W(LEN_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_clr (frame_clr),
    .take      (take),
    .byte_in   (in_data),
    .err_in    (in_err),
    .limit     (limit_q),
    .word_sent (word_sent),
    .word      (pack_word),
    .nbytes    (nbytes),
    .stored    (stored),
    .trunc     (trunc),
    .err_seen  (err_seen),
    .room      (room)
  );

  ringrx_sat_counter #(.W(MISS_W)) u_missed (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (miss_pulse),
    .count (missed_cnt)
  );

  ringrx_next_desc #(.ADDR_W(ADDR_W), .STRIDE(DESC_STRIDE)) u_next (
    .cur  (cur_q),
    .base (base_q),
    .wrap (wrap_q),
    .next (next_desc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      buf_q   <= '0;
      wrap_q  <= 1'b0;
      limit_q <= '0;
      eof_q   <= 1'b0;
      mid_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          mid_q <= 1'b0;
          if (rx_enable) begin
            base_q <= {ring_base[ADDR_W-1:2], 2'b00};
            cur_q  <= {ring_base[ADDR_W-1:2], 2'b00};
            state  <= S_RD_STAT;
          end
        end
        S_RD_STAT: if (xfer) begin
          mid_q <= 1'b0;
          state <= mem_rdata[OWN_BIT] ? S_RD_CTRL : S_STALL;
        end
        S_RD_CTRL: if (xfer) begin
          wrap_q  <= mem_rdata[WRAP_BIT];
          limit_q <= mem_rdata[LEN_W-1:0];
          state   <= S_RD_BUF;
        end
        S_RD_BUF: if (xfer) begin
          buf_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
          eof_q <= 1'b0;
          mid_q <= 1'b0;
          state <= S_RECV;
        end
        S_RECV: begin
          if (accept) begin
            mid_q <= 1'b1;
            if (in_last) begin
              eof_q <= 1'b1;
              state <= (nb_next != 3'd0) ? S_WR_DATA : S_WR_STAT;
            end else if (nb_next == 3'(WORD_BYTES)) begin
              state <= S_WR_DATA;
            end
          end else if (!rx_enable && !mid_q) begin
            state <= S_IDLE;
          end
        end
        S_WR_DATA: if (xfer) begin
          buf_q <= buf_q + ADDR_W'(WORD_BYTES);
          state <= eof_q ? S_WR_STAT : S_RECV;
        end
        S_WR_STAT: if (xfer) begin
          cur_q <= next_desc;
          mid_q <= 1'b0;
          state <= rx_enable ? S_RD_STAT : S_IDLE;
        end
        S_STALL: begin
          if (accept) begin
            mid_q <= !in_last;
          end else if (!mid_q) begin
            state <= rx_enable ? S_RD_STAT : S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ringrx_dma_chk.sv
module ringrx_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic [MISS_W-1:0] missed_cnt
);
  // R10: an open access holds until accepted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3: all accesses are word aligned
  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R11: no byte is taken while the memory port is busy
  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  // R8: the missed count only ever steps up by one
  assert_missed_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == MISS_W'($past(missed_cnt) + 1'b1)));

  // R9: once idle while disabled, no access starts
  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !mem_req && !in_ready) |=> !mem_req);
endmodule

bind ringrx_dma ringrx_dma_chk #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_enable  (rx_enable),
  .in_ready   (in_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .missed_cnt (missed_cnt)
);

// File: tb/ringrx_dma_bench.sv
module ringrx_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst_n, rx_enable, in_valid, in_ready, in_last, in_err;
  logic [31:0] ring_base, mem_addr, mem_wdata, mem_rdata;
  logic [7:0] in_data;
  logic mem_req, mem_we, mem_ready;
  logic [MW-1:0] missed_cnt;

  logic [31:0] mem [0:255];
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  bit          exp_stat[$];
  logic [31:0] mp, base_m, ea, ed;
  bit          es;
  int          exp_missed = 0;
  int          n_checks = 0, n_fail = 0;
  bit          hold_prev = 0;
  logic [31:0] prev_addr, prev_data;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr[9:2]];

  ringrx_dma #(.ADDR_W(32), .LEN_W(11), .MISS_W(MW)) u_ringrx_dma (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_err(in_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .missed_cnt(missed_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int i);
    return 8'(seed + 37 * i);
  endfunction

  // Behavioural model of one frame: fills the expected write queue
  task automatic model_frame(input int n, input int seed, input int err_at, output bit dropped);
    logic [31:0] ctrl, bufa, w;
    int size, stored, nw;
    bit flag;
    dropped = !mem[mp[9:2]][31];
    if (dropped) return;
    ctrl   = mem[(mp + 4) >> 2];
    bufa   = mem[(mp + 8) >> 2] & 32'hFFFF_FFFC;
    size   = int'(ctrl[10:0]);
    stored = (n < size) ? n : size;
    flag   = (err_at >= 0 && err_at < n) || (n > size);
    nw     = (stored + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      w = 0;
      for (int b = 0; b < 4; b++)
        if (k * 4 + b < stored) w = w | (32'(fbyte(seed, k * 4 + b)) << (8 * b));
      exp_addr.push_back(bufa + 32'(4 * k));
      exp_data.push_back(w);
      exp_stat.push_back(1'b0);
    end
    exp_addr.push_back(mp);
    exp_data.push_back((32'(stored) << 16) | (32'(flag) << 15) | 32'h100);
    exp_stat.push_back(1'b1);
    mp = ctrl[25] ? base_m : mp + 32'd16;
  endtask

  task automatic send_frame(input int n, input int seed, input int err_at);
    bit dropped;
    model_frame(n, seed, err_at, dropped);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = fbyte(seed, i);
      in_last  = (i == n - 1);
      in_err   = (i == err_at);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    if (dropped && exp_missed < (1 << MW) - 1) exp_missed++;
  endtask

  task automatic drain();
    while (exp_addr.size() != 0) @(negedge clk);
    repeat (30) @(posedge clk);
    #1;
  endtask

  task automatic put_desc(input logic [31:0] a, input bit own, input int size,
                          input logic [31:0] bufa, input bit wrap);
    mem[a[9:2]]       = {own, 31'd0};
    mem[a[9:2] + 8'd1] = (32'(wrap) << 25) | 32'(size);
    mem[a[9:2] + 8'd2] = bufa;
    mem[a[9:2] + 8'd3] = 32'd0;
  endtask

  // memory stalls one cycle in three
  initial begin
    mem_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      mem_ready = (cyc % 3) != 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(int'(missed_cnt) == exp_missed, "R8", "missed count", missed_cnt, exp_missed);
      chk(!(mem_req && in_ready), "R11", "in_ready with mem_req", {mem_req, in_ready}, 2'b10);
      if (hold_prev)
        chk(mem_req && mem_addr == prev_addr && mem_wdata == prev_data, "R10",
            "held request", mem_addr, prev_addr);
      hold_prev = mem_req && !mem_ready;
      prev_addr = mem_addr;
      prev_data = mem_wdata;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          if (exp_addr.size() == 0) begin
            chk(1'b0, "R8", "unexpected write", mem_addr, 0);
          end else begin
            ea = exp_addr.pop_front();
            ed = exp_data.pop_front();
            es = exp_stat.pop_front();
            chk(mem_addr == ea && mem_wdata == ed, es ? "R4" : "R3", "write addr/data",
                {mem_addr, mem_wdata}, {ea, ed});
          end
          mem[mem_addr[9:2]] = mem_wdata;
        end else begin
          chk(mem_addr == mp || mem_addr == mp + 32'd4 || mem_addr == mp + 32'd8, "R2",
              "descriptor read address", mem_addr, mp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    rst_n = 1'b0; rx_enable = 1'b0; ring_base = 32'd0;
    in_valid = 1'b0; in_data = 8'd0; in_last = 1'b0; in_err = 1'b0;
    mp = 0; base_m = 0;
    repeat (4) @(posedge clk); #1;
    chk(!mem_req && !in_ready && missed_cnt == 0, "R1", "reset outputs",
        {mem_req, in_ready, missed_cnt}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!mem_req && !in_ready && missed_cnt == 0, "R1", "after reset", {mem_req, in_ready}, 0);

    put_desc(32'h40, 1'b1, 16, 32'h100, 1'b0);
    put_desc(32'h50, 1'b1, 10, 32'h200, 1'b0);
    put_desc(32'h60, 1'b1, 64, 32'h300, 1'b1);
    ring_base = 32'h43; base_m = 32'h40; mp = 32'h40;
    rx_enable = 1'b1;
    repeat (30) @(posedge clk); #1;

    send_frame(8, 8'h10, -1);            // R3 two full words
    drain();
    chk(mem[32'h104 >> 2] == {fbyte(8'h10,7), fbyte(8'h10,6), fbyte(8'h10,5), fbyte(8'h10,4)},
        "R3", "second buffer word", mem[32'h104 >> 2], 0);
    send_frame(13, 8'h50, -1);           // R6 truncation at size 10
    drain();
    chk(mem[32'h50 >> 2] == 32'h000A_8100, "R6", "truncated status", mem[32'h50 >> 2], 32'h000A_8100);
    chk(mem[32'h20C >> 2] == 32'd0, "R6", "no write past buffer", mem[32'h20C >> 2], 0);
    send_frame(5, 8'h90, 2);             // R5 error flag, wrap descriptor
    drain();
    chk(mem[32'h60 >> 2] == 32'h0005_8100, "R5", "error status", mem[32'h60 >> 2], 32'h0005_8100);

    for (int f = 0; f < 4; f++) begin    // R8 descriptor at base is host-owned
      send_frame(3 + f, 8'h20 + f, -1);
      repeat (10) @(posedge clk); #1;
    end
    chk(missed_cnt == 2'd3, "R8", "saturated missed count", missed_cnt, 3);

    mem[32'h40 >> 2] = 32'h8000_0000;    // host returns descriptor 0
    repeat (40) @(posedge clk); #1;
    send_frame(4, 8'hC0, -1);
    drain();
    chk(mem[32'h40 >> 2] == 32'h0004_0100, "R7", "wrapped to ring base", mem[32'h40 >> 2], 32'h0004_0100);

    rx_enable = 1'b0;                    // R9 stop
    repeat (20) @(posedge clk); #1;
    chk(!mem_req && !in_ready, "R9", "idle after disable", {mem_req, in_ready}, 0);

    put_desc(32'h80, 1'b1, 6, 32'h380, 1'b1);
    ring_base = 32'h80; base_m = 32'h80; mp = 32'h80;
    rx_enable = 1'b1;
    repeat (30) @(posedge clk); #1;
    send_frame(3, 8'h77, -1);
    drain();
    chk(mem[32'h80 >> 2] == 32'h0003_0100, "R9", "restart from new base", mem[32'h80 >> 2], 32'h0003_0100);
    chk(mem[32'h380 >> 2] == {8'h00, fbyte(8'h77,2), fbyte(8'h77,1), fbyte(8'h77,0)},
        "R3", "partial word zero fill", mem[32'h380 >> 2], 0);
    chk(exp_addr.size() == 0, "R4", "all expected writes seen", exp_addr.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule